// File: doc/BRIEF.md
# Byte-Window Memory Access Port

This block lets a host that can only move single bytes through a small bank of eight I/O registers reach a device's internal 32-bit memory. The host first writes a word-aligned byte address and an access type into two address registers. It then moves data through four data-byte registers. Two further registers are plain mailboxes, one for each direction, that hold whatever the host last wrote.

In byte mode each data register is a direct window onto one byte lane of the addressed word. In the 16-bit and 32-bit modes the data registers sit in front of a four-byte staging register. Reading the lowest lane of a group fetches the group from memory. Writing the highest lane of a group commits the group to memory. The other lanes only touch the staging register. With auto-increment on, an access to the top data lane also steps the word address, so a host can stream a buffer with no further address writes.

The memory port is word addressed with byte enables, and it expects read data in the same cycle as its read enable. The host read data is registered and appears one cycle after the read strobe.

Top module: `bytewin_port`

## Requirements
- R1: After reset, the mailboxes, the address, the access type and the staging register read as zero, and `h_rdata` is zero.
- R2: Offsets 0 and 1 are mailboxes. A read returns the last byte written there, and accesses to offsets 0 to 3 never raise `m_rd` or `m_wr`.
- R3: A write to offset 2 stores bits [7:2] as word-address bits [5:0] and bits [1:0] as the access type (0 byte, 1 16-bit, 2 32-bit, 3 32-bit with auto-increment). A write to offset 3 stores its low 7 bits as word-address bits [12:6]. A read of offset 2 returns {address[5:0], type}, and a read of offset 3 returns {0, address[12:6]}.
- R4: In byte mode, an access to offset 4+k reads or writes memory directly at the current word address with `m_be` equal to 1<<k. The write data is the host byte in every lane, and a read returns lane k of `m_rdata`.
- R5: In both 32-bit modes, a read of offset 4 issues one memory read with `m_be`=4'hF, loads all four lanes into staging and returns lane 0. Reads of offsets 5 to 7 return the staging bytes with no memory read.
- R6: In both 32-bit modes, writes to offsets 4 to 6 update only the staging lane. A write to offset 7 issues one memory write with `m_be`=4'hF carrying the staging bytes, with lane 3 taken from the host byte.
- R7: In auto-increment mode, any read or write of offset 7 advances the word address by one after the load or flush. In all other modes the address changes only through offsets 2 and 3.
- R8: The word address wraps from its top value (all ones) to zero on an advance.
- R9: In 16-bit mode, reads of offsets 4 and 6 load lane pairs {0,1} and {2,3} with `m_be` 4'h3 and 4'hC. Writes of offsets 5 and 7 commit those pairs with the same enables. The other reads and writes use staging only.
- R10: `h_rdata` changes only on the clock edge that ends a cycle with `h_rd` high and `h_wr` low, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_addr | input | 3 | Host register offset |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access; wins over `h_rd` |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid the cycle after `h_rd` |
| m_addr | output | ADDR_W-2 | Memory word address |
| m_rd | output | 1 | Memory read enable |
| m_wr | output | 1 | Memory write enable |
| m_be | output | 4 | Memory byte enables, zero when idle |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data, same cycle as `m_rd` |

## Verification
A corrupted address or access type shows up on `m_addr` and `m_be` at the next data access. It also shows on readback of offsets 2 and 3 one cycle after the read. A bad staging lane is hidden until a read of an upper lane or a commit exposes it. For that reason the bench reads every upper lane and pairs each commit with a byte-mode readback, and the reference model checks the memory side in the same cycle as the strobe. An auto-increment that is wrong by a single step is visible on `m_addr` in the very next access cycle.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'd0,
    ACC_HALF     = 2'd1,
    ACC_WORD     = 2'd2,
    ACC_WORD_INC = 2'd3
  } acc_t;

  localparam logic [2:0] OFF_MBOX_IN  = 3'd0;
  localparam logic [2:0] OFF_MBOX_OUT = 3'd1;
  localparam logic [2:0] OFF_ADDR_LO  = 3'd2;
  localparam logic [2:0] OFF_ADDR_HI  = 3'd3;

  localparam int LANES = 4;

endpackage

// File: rtl/bwp_decode.sv
module bwp_decode
  import bwp_pkg::*;
(
  input  logic [2:0] h_addr,
  input  logic       h_rd,
  input  logic       h_wr,
  input  acc_t       mode,
  output logic       rd_eff,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [3:0] mem_be,
  output logic       stage_load,
  output logic       stage_wr,
  output logic       advance,
  output logic       direct
);

  logic       is_lane;
  logic [1:0] lane;
  logic [3:0] be_raw;

  assign is_lane = h_addr[2];
  assign lane    = h_addr[1:0];
  assign rd_eff  = h_rd & ~h_wr;
  assign direct  = (mode == ACC_BYTE);

  always_comb begin
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    be_raw = 4'h0;
    unique case (mode)
      ACC_BYTE: begin
        mem_rd = is_lane & rd_eff;
        mem_wr = is_lane & h_wr;
        be_raw = 4'h1 << lane;
      end
      ACC_HALF: begin
        mem_rd = is_lane & rd_eff & ~lane[0];
        mem_wr = is_lane & h_wr & lane[0];
        be_raw = lane[1] ? 4'hC : 4'h3;
      end
      default: begin
        mem_rd = is_lane & rd_eff & (lane == 2'd0);
        mem_wr = is_lane & h_wr & (lane == 2'd3);
        be_raw = 4'hF;
      end
    endcase
  end

  assign mem_be     = (mem_rd | mem_wr) ? be_raw : 4'h0;
  assign stage_load = mem_rd & ~direct;
  assign stage_wr   = is_lane & h_wr & ~direct;
  assign advance    = is_lane & (rd_eff | h_wr) & (lane == 2'd3) &
                      (mode == ACC_WORD_INC);

endmodule

// File: rtl/bwp_addr_regs.sv
module bwp_addr_regs
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              h_wr,
  input  logic [7:0]        h_wdata,
  input  logic              advance,
  output logic [ADDR_W-3:0] waddr,
  output acc_t              mode,
  output logic [7:0]        mbox [2]
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int HI_W   = ADDR_W - 8;

  logic [WORD_W-1:0] waddr_q, waddr_d;
  acc_t              mode_q, mode_d;
  logic              wr_lo, wr_hi, addr_en;

  assign wr_lo   = h_wr & (h_addr == OFF_ADDR_LO);
  assign wr_hi   = h_wr & (h_addr == OFF_ADDR_HI);
  assign addr_en = wr_lo | wr_hi | advance;

  always_comb begin
    waddr_d = waddr_q;
    mode_d  = mode_q;
    if (wr_lo) begin
      waddr_d[5:0] = h_wdata[7:2];
      mode_d       = acc_t'(h_wdata[1:0]);
    end else if (wr_hi) begin
      waddr_d[WORD_W-1:6] = h_wdata[HI_W-1:0];
    end else if (advance) begin
      waddr_d = waddr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      mode_q  <= ACC_BYTE;
    end else if (addr_en) begin
      waddr_q <= waddr_d;
      mode_q  <= mode_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_mbox
    logic       mb_en;
    logic [7:0] mb_q;
    assign mb_en = h_wr & (h_addr == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mb_q <= '0;
      else if (mb_en) mb_q <= h_wdata;
    end
    assign mbox[g] = mb_q;
  end

  assign waddr = waddr_q;
  assign mode  = mode_q;

endmodule

// File: rtl/bwp_stage.sv
module bwp_stage
  import bwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lane,
  input  logic        stage_load,
  input  logic        stage_wr,
  input  logic        direct,
  input  logic [3:0]  mem_be,
  input  logic [7:0]  h_wdata,
  input  logic [31:0] m_rdata,
  output logic [31:0] stage,
  output logic [31:0] wdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       en;
    logic [7:0] d, q;
    logic       host_hit;

    assign host_hit = (lane == 2'(g));
    assign en       = (stage_load & mem_be[g]) | (stage_wr & host_hit);

    always_comb begin
      if (stage_load) d = m_rdata[8*g +: 8];
      else            d = h_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign stage[8*g +: 8] = q;
    assign wdata[8*g +: 8] = (direct | host_hit) ? h_wdata : q;
  end

endmodule

// File: rtl/bwp_rdpath.sv
module bwp_rdpath
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              rd_eff,
  input  logic              mem_rd,
  input  logic [ADDR_W-3:0] waddr,
  input  acc_t              mode,
  input  logic [7:0]        mbox [2],
  input  logic [31:0]       stage,
  input  logic [31:0]       m_rdata,
  output logic [7:0]        h_rdata
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int HI_W   = ADDR_W - 8;

  logic [7:0] hi_byte, sel_d, rdata_q;
  logic [1:0] lane;

  assign lane = h_addr[1:0];

  always_comb begin
    hi_byte           = '0;
    hi_byte[HI_W-1:0] = waddr[WORD_W-1:6];
  end

  always_comb begin
    if (h_addr[2]) begin
      sel_d = mem_rd ? m_rdata[8*lane +: 8] : stage[8*lane +: 8];
    end else begin
      unique case (h_addr[1:0])
        2'd0:    sel_d = mbox[0];
        2'd1:    sel_d = mbox[1];
        2'd2:    sel_d = {waddr[5:0], mode};
        default: sel_d = hi_byte;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_eff) rdata_q <= sel_d;
  end

  assign h_rdata = rdata_q;

endmodule

// File: rtl/bytewin_port.sv
module bytewin_port
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic [ADDR_W-3:0] m_addr,
  output logic              m_rd,
  output logic              m_wr,
  output logic [3:0]        m_be,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata
);

  localparam int WORD_W = ADDR_W - 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  acc_t              acc_mode;
  logic [WORD_W-1:0] waddr;
  logic [7:0]        mbox [2];
  logic              rd_eff, mem_rd, mem_wr, stage_load, stage_wr, advance, direct;
  logic [3:0]        mem_be;
  logic [31:0]       stage, wdata;

  bwp_decode u_dec (
    .h_addr     (h_addr),
    .h_rd       (h_rd),
    .h_wr       (h_wr),
    .mode       (acc_mode),
    .rd_eff     (rd_eff),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_be     (mem_be),
    .stage_load (stage_load),
    .stage_wr   (stage_wr),
    .advance    (advance),
    .direct     (direct)
  );

  bwp_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .h_addr  (h_addr),
    .h_wr    (h_wr),
    .h_wdata (h_wdata),
    .advance (advance),
    .waddr   (waddr),
    .mode    (acc_mode),
    .mbox    (mbox)
  );

  bwp_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lane       (h_addr[1:0]),
    .stage_load (stage_load),
    .stage_wr   (stage_wr),
    .direct     (direct),
    .mem_be     (mem_be),
    .h_wdata    (h_wdata),
    .m_rdata    (m_rdata),
    .stage      (stage),
    .wdata      (wdata)
  );

  bwp_rdpath #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .h_addr  (h_addr),
    .rd_eff  (rd_eff),
    .mem_rd  (mem_rd),
    .waddr   (waddr),
    .mode    (acc_mode),
    .mbox    (mbox),
    .stage   (stage),
    .m_rdata (m_rdata),
    .h_rdata (h_rdata)
  );

  assign m_addr  = waddr;
  assign m_rd    = mem_rd;
  assign m_wr    = mem_wr;
  assign m_be    = mem_be;
  assign m_wdata = wdata;

endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
  parameter int WORD_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        h_addr,
  input logic              h_rd,
  input logic              h_wr,
  input logic [7:0]        h_rdata,
  input logic [WORD_W-1:0] m_addr,
  input logic              m_rd,
  input logic              m_wr,
  input logic [3:0]        m_be,
  input logic [1:0]        mode
);

  a_r2_regs_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_rd || h_wr) && !h_addr[2]) |-> (!m_rd && !m_wr));

  a_r4_mem_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd |-> (h_rd && !h_wr)) and (m_wr |-> h_wr));

  a_r4_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd || m_wr) && mode == 2'd0) |-> ($countones(m_be) == 1));

  a_r5_load_on_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && mode[1]) |-> (h_addr == 3'd4 && m_be == 4'hF));

  a_r6_flush_on_lane3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && mode[1]) |-> (h_addr == 3'd7 && m_be == 4'hF));

  a_r9_half_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd || m_wr) && mode == 2'd1) |-> (m_be == 4'h3 || m_be == 4'hC));

  a_r7_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_rd || h_wr) && h_addr == 3'd7 && mode == 2'd3)
      |=> (m_addr == WORD_W'($past(m_addr) + 1'b1)));

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_wr && !(h_rd && h_addr == 3'd7 && mode == 2'd3)) |=> $stable(m_addr));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rd || h_wr) |=> $stable(h_rdata));

endmodule

bind bytewin_port bwp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .h_addr  (h_addr),
  .h_rd    (h_rd),
  .h_wr    (h_wr),
  .h_rdata (h_rdata),
  .m_addr  (m_addr),
  .m_rd    (m_rd),
  .m_wr    (m_wr),
  .m_be    (m_be),
  .mode    (acc_mode)
);

// File: tb/bytewin_port_test.sv
`timescale 1ns/1ps
module bytewin_port_test;

  localparam int AW = 15;
  localparam int WW = AW - 2;
  localparam int WMASK = (1 << WW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    h_addr;
  logic          h_rd, h_wr;
  logic [7:0]    h_wdata, h_rdata;
  logic [WW-1:0] m_addr;
  logic          m_rd, m_wr;
  logic [3:0]    m_be;
  logic [31:0]   m_wdata, m_rdata;

  always #2.5 clk = ~clk;

  bytewin_port #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .m_addr(m_addr), .m_rd(m_rd),
    .m_wr(m_wr), .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  // memory seen by the design
  logic [7:0] dut_mem [int];
  int         mem_ev = 0;

  function automatic logic [7:0] seed(int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [7:0] dget(int a);
    return dut_mem.exists(a) ? dut_mem[a] : seed(a);
  endfunction

  always @(m_addr, mem_ev) begin
    m_rdata = {dget(int'(m_addr) * 4 + 3), dget(int'(m_addr) * 4 + 2),
               dget(int'(m_addr) * 4 + 1), dget(int'(m_addr) * 4)};
  end

  always @(posedge clk) begin
    if (m_wr) begin
      for (int i = 0; i < 4; i++)
        if (m_be[i]) dut_mem[int'(m_addr) * 4 + i] = m_wdata[8*i +: 8];
      mem_ev = mem_ev + 1;
    end
  end

  // reference model state
  logic [7:0] ref_mem [int];
  int         r_wa, r_mode;
  logic [7:0] r_mb [2];
  logic [7:0] r_st [4];
  logic [7:0] r_rdata;
  int         n_cmp = 0, n_bad = 0;

  function automatic logic [7:0] rget(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed(a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit rd, bit wr, int off, logic [7:0] d, string req);
    logic [7:0]  prev;
    int          old_wa, k;
    bit          e_rd, e_wr;
    logic [3:0]  e_be;
    logic [31:0] e_wd, mask;
    @(negedge clk);
    h_addr = 3'(off); h_rd = rd; h_wr = wr; h_wdata = d;
    prev = r_rdata; old_wa = r_wa;
    e_rd = 0; e_wr = 0; e_be = 0; e_wd = 0;
    k = off - 4;
    if (wr) begin
      case (off)
        0, 1: r_mb[off] = d;
        2: begin r_wa = (r_wa & ~63) | int'(d >> 2); r_mode = int'(d & 8'h3); end
        3: r_wa = (r_wa & 63) | (int'(d & 8'h7f) << 6);
        default: begin
          if (r_mode == 0) begin
            e_wr = 1; e_be = 4'(1 << k); e_wd = {4{d}};
            ref_mem[old_wa * 4 + k] = d;
          end else begin
            r_st[k] = d;
            if (r_mode == 1 && (k % 2) == 1) begin
              e_wr = 1; e_be = (k == 1) ? 4'h3 : 4'hC;
              ref_mem[old_wa * 4 + k - 1] = r_st[k-1];
              ref_mem[old_wa * 4 + k]     = r_st[k];
            end else if (r_mode >= 2 && k == 3) begin
              e_wr = 1; e_be = 4'hF;
              for (int i = 0; i < 4; i++) ref_mem[old_wa * 4 + i] = r_st[i];
            end
            e_wd = {r_st[3], r_st[2], r_st[1], r_st[0]};
          end
        end
      endcase
    end else if (rd) begin
      case (off)
        0, 1: r_rdata = r_mb[off];
        2: r_rdata = 8'(((r_wa & 63) << 2) | r_mode);
        3: r_rdata = 8'((r_wa >> 6) & 127);
        default: begin
          if (r_mode == 0) begin
            e_rd = 1; e_be = 4'(1 << k); r_rdata = rget(old_wa * 4 + k);
          end else begin
            if (r_mode == 1 && (k % 2) == 0) begin
              e_rd = 1; e_be = (k == 0) ? 4'h3 : 4'hC;
              r_st[k] = rget(old_wa * 4 + k); r_st[k+1] = rget(old_wa * 4 + k + 1);
            end else if (r_mode >= 2 && k == 0) begin
              e_rd = 1; e_be = 4'hF;
              for (int i = 0; i < 4; i++) r_st[i] = rget(old_wa * 4 + i);
            end
            r_rdata = r_st[k];
          end
        end
      endcase
    end
    if ((rd || wr) && off == 7 && r_mode == 3) r_wa = (old_wa + 1) & WMASK;
    #1;
    chk({req, " h_rdata"}, {24'h0, h_rdata}, {24'h0, prev});
    chk({req, " mem strobes"}, {26'h0, m_rd, m_wr, m_be}, {26'h0, e_rd, e_wr, e_be});
    if (e_rd || e_wr) chk({req, " m_addr"}, 32'(m_addr), 32'(old_wa));
    if (e_wr) begin
      mask = {{8{e_be[3]}}, {8{e_be[2]}}, {8{e_be[1]}}, {8{e_be[0]}}};
      chk({req, " m_wdata"}, m_wdata & mask, e_wd & mask);
    end
  endtask

  task automatic rd_reg(int off, string req);  cyc(1, 0, off, 8'h00, req); endtask
  task automatic wr_reg(int off, logic [7:0] d, string req); cyc(0, 1, off, d, req); endtask
  task automatic idle(string req); cyc(0, 0, 0, 8'h00, req); endtask

  task automatic set_addr(int wa, int mode, string req);
    wr_reg(2, 8'(((wa & 63) << 2) | mode), req);
    wr_reg(3, 8'((wa >> 6) & 127), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    h_addr = 0; h_rd = 0; h_wr = 0; h_wdata = 0;
    r_wa = 0; r_mode = 0; r_rdata = 0;
    r_mb[0] = 0; r_mb[1] = 0;
    for (int i = 0; i < 4; i++) r_st[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    idle("R1");
    rd_reg(0, "R1"); rd_reg(1, "R1"); rd_reg(2, "R1"); rd_reg(3, "R1");
    wr_reg(2, 8'h02, "R1");
    rd_reg(5, "R1"); rd_reg(6, "R1"); rd_reg(7, "R1");

    // R2 mailboxes
    wr_reg(0, 8'hA5, "R2"); wr_reg(1, 8'h3C, "R2");
    rd_reg(0, "R2"); rd_reg(1, "R2");
    wr_reg(0, 8'h00, "R2"); rd_reg(0, "R2"); rd_reg(1, "R2");

    // R3 address registers
    wr_reg(2, 8'hB5, "R3"); wr_reg(3, 8'hFF, "R3");
    rd_reg(2, "R3"); rd_reg(3, "R3");
    wr_reg(3, 8'h2A, "R3"); rd_reg(3, "R3"); rd_reg(2, "R3");

    // R4 byte mode
    set_addr(12'h123, 0, "R4");
    for (int k = 4; k < 8; k++) rd_reg(k, "R4");
    wr_reg(5, 8'h77, "R4"); wr_reg(6, 8'h88, "R4");
    for (int k = 4; k < 8; k++) rd_reg(k, "R4");

    // R5 word read, R10 hold
    set_addr(12'h040, 2, "R5");
    for (int k = 4; k < 8; k++) rd_reg(k, "R5");
    idle("R10"); idle("R10");
    rd_reg(6, "R5"); rd_reg(4, "R5");

    // R6 word write then byte readback
    set_addr(12'h041, 2, "R6");
    wr_reg(4, 8'h11, "R6"); wr_reg(5, 8'h22, "R6"); wr_reg(6, 8'h33, "R6");
    rd_reg(5, "R6");
    wr_reg(7, 8'h44, "R6");
    wr_reg(2, 8'(((12'h041 & 63) << 2) | 0), "R6");
    for (int k = 4; k < 8; k++) rd_reg(k, "R6");

    // R7 auto-increment streaming writes and reads
    set_addr(12'h200, 3, "R7");
    for (int w = 0; w < 3; w++)
      for (int k = 4; k < 8; k++) wr_reg(k, 8'(w * 16 + k), "R7");
    rd_reg(2, "R7"); rd_reg(3, "R7");
    set_addr(12'h200, 3, "R7");
    for (int w = 0; w < 3; w++)
      for (int k = 4; k < 8; k++) rd_reg(k, "R7");
    set_addr(12'h300, 2, "R7");
    rd_reg(7, "R7"); wr_reg(7, 8'h5A, "R7"); rd_reg(2, "R7");

    // R8 wrap at top of address space
    set_addr(WMASK, 3, "R8");
    rd_reg(4, "R8"); rd_reg(7, "R8");
    rd_reg(2, "R8"); rd_reg(3, "R8");
    set_addr(WMASK, 3, "R8");
    wr_reg(7, 8'hE1, "R8"); rd_reg(2, "R8"); rd_reg(3, "R8");

    // R9 16-bit mode
    set_addr(12'h0A0, 1, "R9");
    for (int k = 4; k < 8; k++) rd_reg(k, "R9");
    wr_reg(4, 8'hC0, "R9"); wr_reg(5, 8'hC1, "R9");
    wr_reg(6, 8'hC2, "R9"); rd_reg(7, "R9"); wr_reg(7, 8'hC3, "R9");
    rd_reg(2, "R9");
    wr_reg(2, 8'(((12'h0A0 & 63) << 2) | 0), "R9");
    for (int k = 4; k < 8; k++) rd_reg(k, "R9");

    idle("R10"); idle("R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule